// File: doc/BRIEF.md
# Encoded Programmable Reference Divider

This block divides an input clock by a ratio between 1 and 2055. The ratio comes from a 13-bit packed control word, not a plain binary count. The two least significant bits select one of three packing schemes. A narrow scheme gives ratios 1 and 2. A middle scheme stores an inverted offset in four bits. A wide scheme stores an eleven-bit offset. The divided output drives a phase comparator, so it must never produce a shortened period.

The word is decoded into a ratio every cycle. That ratio is only copied into the active configuration when the running period ends. The output is either a one-cycle-wide pulse per period or a near-square wave, as chosen by a select input. A ratio of 1 bypasses the counter and gates the input clock straight through.

Top module: `ref_div_top`

## Requirements
- R1: With ctrl_word[1:0] = 00 the ratio is 1, and div_out equals clk_in (high while clk_in is high, low while it is low). With ctrl_word[1:0] = 01 the ratio is 2.
- R2: With ctrl_word[1:0] = 10 the ratio is the bitwise inverse of ctrl_word[5:2] plus 2. For example, 1110 gives 3, 0000 gives 17 and 1111 gives 2.
- R3: With ctrl_word[1:0] = 10, bits ctrl_word[12:6] have no effect on the ratio.
- R4: With ctrl_word[1:0] = 11 the ratio is ctrl_word[12:2] plus 8. Any result below 18 is raised to 18, so the ratio runs from 18 to 2055.
- R5: While rst is high, div_out is low. The active ratio after reset is 5 in pulse form, whatever ctrl_word holds: the first rising edge of div_out comes on the 5th rising edge of clk_in after rst falls.
- R6: With square_sel = 0 and a ratio N of 2 or more, div_out is high for exactly one clk_in cycle in every N cycles.
- R7: With square_sel = 1 and a ratio N of 2 or more, div_out is high for floor(N/2) cycles and low for the remaining cycles of each N-cycle period.
- R8: A change of ctrl_word or square_sel takes effect only when the current period ends. The period in progress keeps its full length, and div_out rises at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 13 | Packed ratio word; bits [1:0] select the packing scheme |
| square_sel | input | 1 | 0 selects a one-cycle pulse output, 1 selects a near-square output |
| div_out | output | 1 | Divided clock |

## Verification
The ratio decoding is tried with words from each packing scheme, including both ends of the middle range and the wide maximum of 2055. The period measured at the output tells apart an off-by-one in the offset, a missing inversion and a wrong scheme choice. Words with junk in the unused upper bits of the middle scheme, and wide-scheme offsets below 18, show whether don't-care bits leak into the ratio and whether the lower bound is enforced. The high-time count in both output forms separates pulse shaping from square shaping. A ratio change made in the middle of a long period shows whether the load is deferred to the period boundary or the period is cut short.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;

    localparam int CW_W        = 13;
    localparam int RATIO_W     = 12;
    localparam int MID_W       = 4;
    localparam int WIDE_W      = CW_W - 2;
    localparam int MID_OFFSET  = 2;
    localparam int WIDE_OFFSET = 8;
    localparam int WIDE_FLOOR  = 18;

    typedef enum logic [1:0] {
        PK_ONE   = 2'b00,
        PK_TWO   = 2'b01,
        PK_MID   = 2'b10,
        PK_WIDE  = 2'b11
    } pack_mode_t;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               square;
    } div_cfg_t;

    function automatic logic [RATIO_W-1:0] decode_ratio(input logic [CW_W-1:0] w);
        logic [RATIO_W-1:0] r;
        logic [MID_W-1:0]   mid_inv;
        mid_inv = ~w[MID_W+1:2];
        case (pack_mode_t'(w[1:0]))
            PK_ONE:  r = RATIO_W'(1);
            PK_TWO:  r = RATIO_W'(2);
            PK_MID:  r = RATIO_W'(mid_inv) + RATIO_W'(MID_OFFSET);
            default: begin
                r = RATIO_W'(w[CW_W-1:2]) + RATIO_W'(WIDE_OFFSET);
                if (r < RATIO_W'(WIDE_FLOOR))
                    r = RATIO_W'(WIDE_FLOOR);
            end
        endcase
        return r;
    endfunction

    function automatic logic [RATIO_W-1:0] high_len(input logic [RATIO_W-1:0] ratio);
        return ratio >> 1;
    endfunction

endpackage

// File: rtl/ref_div_decode.sv
module ref_div_decode
    import ref_div_pkg::*;
(
    input  logic [CW_W-1:0] ctrl_word,
    input  logic            square_sel,
    output div_cfg_t        cfg
);

    always_comb begin
        cfg.ratio  = decode_ratio(ctrl_word);
        cfg.square = square_sel;
    end

endmodule

// File: rtl/ref_div_count.sv
module ref_div_count
    import ref_div_pkg::*;
#(
    parameter int RESET_RATIO = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  div_cfg_t           cfg_in,
    output div_cfg_t           cur_cfg,
    output div_cfg_t           nxt_cfg,
    output logic [RATIO_W-1:0] nxt_cnt
);

    logic [RATIO_W-1:0] cnt;
    logic               at_end;

    assign at_end  = (cnt == cur_cfg.ratio - RATIO_W'(1));
    assign nxt_cnt = at_end ? '0 : cnt + RATIO_W'(1);
    assign nxt_cfg = at_end ? cfg_in : cur_cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt            <= '0;
            cur_cfg.ratio  <= RATIO_W'(RESET_RATIO);
            cur_cfg.square <= 1'b0;
        end else begin
            cnt     <= nxt_cnt;
            cur_cfg <= nxt_cfg;
        end
    end

    AST_CNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (rst)
        cnt < cur_cfg.ratio);                                         // R6
    AST_CFG_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
        !at_end |=> $stable(cur_cfg));                                // R8
    AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        at_end |=> (cnt == '0));                                      // R8

endmodule

// File: rtl/ref_div_shape.sv
module ref_div_shape
    import ref_div_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  div_cfg_t           cur_cfg,
    input  div_cfg_t           nxt_cfg,
    input  logic [RATIO_W-1:0] nxt_cnt,
    output logic               div_out
);

    logic out_q;
    logic bypass;

    assign bypass = (cur_cfg.ratio == RATIO_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= 1'b0;
        else if (nxt_cfg.square)
            out_q <= (nxt_cnt < high_len(nxt_cfg.ratio));
        else
            out_q <= (nxt_cnt == '0);
    end

    assign div_out = bypass ? clk : out_q;

    AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        (out_q && !cur_cfg.square && !bypass) |=> !out_q);            // R6

endmodule

// File: rtl/ref_div_top.sv
module ref_div_top
    import ref_div_pkg::*;
#(
    parameter int RESET_RATIO = 5
) (
    input  logic            clk_in,
    input  logic            rst,
    input  logic [12:0]     ctrl_word,
    input  logic            square_sel,
    output logic            div_out
);

    div_cfg_t           dec_cfg;
    div_cfg_t           cur_cfg;
    div_cfg_t           nxt_cfg;
    logic [RATIO_W-1:0] nxt_cnt;

    ref_div_decode u_decode (
        .ctrl_word  (ctrl_word),
        .square_sel (square_sel),
        .cfg        (dec_cfg)
    );

    ref_div_count #(.RESET_RATIO(RESET_RATIO)) u_count (
        .clk     (clk_in),
        .rst     (rst),
        .cfg_in  (dec_cfg),
        .cur_cfg (cur_cfg),
        .nxt_cfg (nxt_cfg),
        .nxt_cnt (nxt_cnt)
    );

    ref_div_shape u_shape (
        .clk     (clk_in),
        .rst     (rst),
        .cur_cfg (cur_cfg),
        .nxt_cfg (nxt_cfg),
        .nxt_cnt (nxt_cnt),
        .div_out (div_out)
    );

    AST_WIDE_AT_LEAST_FLOOR: assert property (@(posedge clk_in) disable iff (rst)
        (ctrl_word[1:0] == 2'b11) |-> (dec_cfg.ratio >= RATIO_W'(WIDE_FLOOR)));   // R4
    AST_NARROW_SMALL: assert property (@(posedge clk_in) disable iff (rst)
        (ctrl_word[1] == 1'b0) |-> (dec_cfg.ratio <= RATIO_W'(2)));                // R1
    AST_MID_RANGE: assert property (@(posedge clk_in) disable iff (rst)
        (ctrl_word[1:0] == 2'b10) |-> (dec_cfg.ratio >= RATIO_W'(2) && dec_cfg.ratio <= RATIO_W'(17))); // R2
    AST_RESET_OUT_LOW: assert property (@(posedge clk_in)
        rst |=> !div_out);                                                         // R5

endmodule

// File: tb/ref_div_top_bench.sv
`timescale 1ns/1ps
module ref_div_top_bench;

    logic        clk_in = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] ctrl_word = 13'h0;
    logic        square_sel = 1'b0;
    logic        div_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk_in = ~clk_in;

    ref_div_top u_ref_div_top (
        .clk_in     (clk_in),
        .rst        (rst),
        .ctrl_word  (ctrl_word),
        .square_sel (square_sel),
        .div_out    (div_out)
    );

    localparam int NV = 11;
    localparam logic [12:0] V_CTRL [NV] = '{
        13'h0001, 13'h1FFD, 13'h003A, 13'h0002, 13'h003E, 13'h1FEE,
        13'h002B, 13'h000F, 13'h0003, 13'h0173, 13'h1FFF };
    localparam bit V_SQ [NV] = '{
        1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0,
        1'b1, 1'b0, 1'b1, 1'b1, 1'b0 };
    localparam int V_RATIO [NV] = '{
        2, 2, 3, 17, 2, 6,
        18, 18, 18, 100, 2055 };
    localparam string V_REQ [NV] = '{
        "R1", "R1", "R2", "R2", "R2", "R3",
        "R4", "R4", "R4", "R4", "R4" };

    task automatic check(input string req, input int actual, input int expected, input string what);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    task automatic wait_rise();
        logic prev;
        @(negedge clk_in);
        prev = div_out;
        for (int g = 0; g < 6000; g++) begin
            @(negedge clk_in);
            if (!prev && div_out) return;
            prev = div_out;
        end
    endtask

    task automatic measure(input string req, input int exp_hi, input int exp_per);
        int hi;
        int lo;
        wait_rise();
        hi = 1;
        lo = 0;
        for (int g = 0; g < 6000; g++) begin
            @(negedge clk_in);
            if (div_out) begin
                if (lo > 0) break;
                hi++;
            end else begin
                lo++;
            end
        end
        check(req, hi, exp_hi, "high cycles");
        check(req, hi + lo, exp_per, "period");
    endtask

    initial begin
        int n;
        int lows;
        // reset with a different word already present: default ratio must govern first period
        ctrl_word = 13'h003A;
        square_sel = 1'b0;
        repeat (4) @(posedge clk_in);
        @(negedge clk_in);
        check("R5", int'(div_out), 0, "output during reset");
        rst = 1'b0;
        lows = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk_in);
            if (div_out) break;
            lows++;
        end
        check("R5", lows, 4, "low samples before first rise");

        // table of vectors
        for (int i = 0; i < NV; i++) begin
            ctrl_word = V_CTRL[i];
            square_sel = V_SQ[i];
            measure(V_REQ[i], V_SQ[i] ? V_RATIO[i] / 2 : 1, V_RATIO[i]);
        end
        // extra labelled shape checks: R6 pulse, R7 square
        ctrl_word = 13'h0026; square_sel = 1'b0;   // mid 1001 -> 8
        measure("R6", 1, 8);
        square_sel = 1'b1;
        measure("R7", 4, 8);

        // ratio 1 passthrough
        ctrl_word = 13'h1FFC; square_sel = 1'b0;
        repeat (30) @(negedge clk_in);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk_in); #1;
            check("R1", int'(div_out), 1, "bypass high phase");
            @(negedge clk_in); #1;
            check("R1", int'(div_out), 0, "bypass low phase");
        end

        // change in the middle of a long period
        ctrl_word = 13'h0173; square_sel = 1'b0;   // ratio 100
        measure("R4", 1, 100);
        wait_rise();
        n = 1;
        for (int g = 0; g < 500; g++) begin
            @(negedge clk_in);
            if (div_out) break;
            n++;
            if (n == 10) ctrl_word = 13'h003A;
        end
        check("R8", n, 100, "period in progress when word changed");
        measure("R8", 1, 3);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule